// File: doc/BRIEF.md
# Video Component Output Range Formatter

This block is the last pipeline stage of a colour conversion datapath. It takes six signed fixed-point intermediate results for one pixel: three primaries (R, G, B), one luma (Y) and two colour-difference values (Cr, Cb). Each result has 12 integer bits and 4 fraction bits. The block rounds each value to an integer and saturates it to an 8-bit code. It can then re-encode the chroma codes. A valid flag travels alongside the pixel. After exactly two clock edges the formatted pixel appears with its own valid flag.

Two control inputs select the output coding. `range_studio` chooses between full coding (0 to 255) and studio coding. Studio coding keeps primaries and luma within 16 to 235, and chroma within 16 to 240. `chroma_twos` selects how the two chroma channels are coded. When it is clear they leave as offset binary, with 128 as the zero point. When it is set their MSB is inverted, which gives two's complement. The primaries and luma always stay unsigned. The block latches the pair of control bits only while no pixel is entering or in flight, so every pixel of a burst is coded the same way.

Top module: `vcof_formatter`

## Requirements
- R1: Each input x (signed, value x/16) is rounded half-up to floor((x+8)/16) before limiting; e.g. x=24 (1.5) gives 2, x=23 gives 1, x=-8 (-0.5) gives 0.
- R2: With the active range bit 0, every channel saturates to 0..255: negative results give 0x00, results above 255 give 0xFF.
- R3: With the active range bit 1, channels 0..3 of the pixel vector (R, G, B, Y) saturate to 16..235.
- R4: With the active range bit 1, channels 4 and 5 (Cr, Cb) saturate to 16..240 in the offset-binary domain.
- R5: Channels 0..3 are unsigned codes regardless of the sign-select bit.
- R6: With the active sign bit 0, channels 4 and 5 are output as the limited offset-binary code (0x80 = zero).
- R7: With the active sign bit 1, channels 4 and 5 are the limited code with bit 7 inverted (0x80 becomes 0x00, 0x7F becomes 0xFF); in studio range they therefore span -112 (0x90) to +112 (0x70).
- R8: A pixel accepted with `in_valid` high on a clock edge appears on `out_px` with `out_valid` high after the second following edge; `out_px` holds its value while `out_valid` is low.
- R9: The control pair is captured only at an edge where `in_valid` is low and no pixel sits in the first stage; a change of the control inputs during a burst does not affect pixels of that burst.
- R10: Synchronous reset clears `out_valid` and `out_px` and sets the active format to full range with offset-binary chroma.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| range_studio | input | 1 | Requested range: 0 full, 1 studio |
| chroma_twos | input | 1 | Requested chroma coding: 0 offset binary, 1 two's complement |
| in_valid | input | 1 | Input pixel present |
| in_px | input | 6x16 | Signed Q12.4 intermediates; index 0..5 = R, G, B, Y, Cr, Cb |
| out_valid | output | 1 | Output pixel present |
| out_px | output | 6x8 | Formatted 8-bit codes, same channel order |

## Verification
On every cycle the assertions check several invariants. Studio-range luma and chroma codes must stay inside their windows. Studio two's-complement chroma must stay within ±112. The valid flag must follow two edges after input, and idle output must hold. The active format must not move while a pixel is entering or in flight, and reset must clear the outputs. Only the bench scenarios can show that each code has the exact value expected. These include the half-up rounding points, saturation of extreme inputs, the bit-7 inversion at the chroma zero point, the default format at reset, and a control change in the middle of a burst that takes effect only after the pipeline drains.

// File: rtl/vcof_pkg.sv
package vcof_pkg;

    localparam int NCH    = 6;
    localparam int CODE_W = 8;

    // channel order inside the pixel vector
    localparam int CH_R  = 0;
    localparam int CH_G  = 1;
    localparam int CH_B  = 2;
    localparam int CH_Y  = 3;
    localparam int CH_CR = 4;
    localparam int CH_CB = 5;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t FULL_LO          = 8'd0;
    localparam code_t FULL_HI          = 8'd255;
    localparam code_t STUDIO_LO        = 8'd16;
    localparam code_t STUDIO_LUMA_HI   = 8'd235;
    localparam code_t STUDIO_CHROMA_HI = 8'd240;

    typedef enum logic {
        KIND_LUMA   = 1'b0,
        KIND_CHROMA = 1'b1
    } kind_e;

    typedef struct packed {
        logic studio;
        logic twos;
    } fmt_t;

    typedef struct packed {
        logic                 valid;
        code_t [NCH-1:0]      code;
    } stage_t;

    function automatic kind_e kind_of(int ch);
        return (ch == CH_CR || ch == CH_CB) ? KIND_CHROMA : KIND_LUMA;
    endfunction

    function automatic code_t low_limit(fmt_t f);
        return f.studio ? STUDIO_LO : FULL_LO;
    endfunction

    function automatic code_t high_limit(fmt_t f, kind_e k);
        if (!f.studio)
            return FULL_HI;
        return (k == KIND_CHROMA) ? STUDIO_CHROMA_HI : STUDIO_LUMA_HI;
    endfunction

    // offset binary to two's complement: flip the top bit
    function automatic code_t to_twos(code_t c);
        return {~c[CODE_W-1], c[CODE_W-2:0]};
    endfunction

endpackage

// File: rtl/vcof_round_sat.sv
// Rounds one signed fixed-point value half-up and clamps it to the
// window of the active format. Requires IN_W - FRAC >= 9.
module vcof_round_sat
    import vcof_pkg::*;
#(
    parameter int    IN_W = 16,
    parameter int    FRAC = 4,
    parameter kind_e KIND = KIND_LUMA
) (
    input  logic [IN_W-1:0] din,
    input  fmt_t            fmt,
    output code_t           code
);

    localparam int EW = IN_W + 1;

    logic signed [EW-1:0] ext;
    logic signed [EW-1:0] biased;
    logic signed [EW-1:0] whole;
    logic signed [EW-1:0] lo_s;
    logic signed [EW-1:0] hi_s;
    code_t                lo_c;
    code_t                hi_c;

    assign ext = {din[IN_W-1], din};

    generate
        if (FRAC > 0) begin : g_round
            localparam logic signed [EW-1:0] HALF = EW'(1) << (FRAC - 1);
            assign biased = ext + HALF;
        end else begin : g_noround
            assign biased = ext;
        end
    endgenerate

    assign whole = biased >>> FRAC;

    assign lo_c = low_limit(fmt);
    assign hi_c = high_limit(fmt, KIND);
    assign lo_s = {{(EW-CODE_W){1'b0}}, lo_c};
    assign hi_s = {{(EW-CODE_W){1'b0}}, hi_c};

    always_comb begin
        if (whole < lo_s)
            code = lo_c;
        else if (whole > hi_s)
            code = hi_c;
        else
            code = whole[CODE_W-1:0];
    end

endmodule

// File: rtl/vcof_cfg_gate.sv
// Holds the active format; accepts a new request only while the
// pipeline front is empty.
module vcof_cfg_gate
    import vcof_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic studio_req,
    input  logic twos_req,
    input  logic in_valid,
    input  logic s1_valid,
    output fmt_t fmt_q
);

    logic idle;
    assign idle = !in_valid && !s1_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            fmt_q <= '0;
        end else if (idle) begin
            fmt_q.studio <= studio_req;
            fmt_q.twos   <= twos_req;
        end
    end

endmodule

// File: rtl/vcof_encode.sv
// Re-codes the chroma channels; luma-class channels pass unchanged.
module vcof_encode
    import vcof_pkg::*;
(
    input  code_t [NCH-1:0] code_in,
    input  fmt_t            fmt,
    output code_t [NCH-1:0] code_out
);

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            if (kind_of(g) == KIND_CHROMA) begin : g_chroma
                assign code_out[g] = fmt.twos ? to_twos(code_in[g]) : code_in[g];
            end else begin : g_luma
                assign code_out[g] = code_in[g];
            end
        end
    endgenerate

endmodule

// File: rtl/vcof_formatter.sv
module vcof_formatter
    import vcof_pkg::*;
#(
    parameter int IN_W = 16,
    parameter int FRAC = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       range_studio,
    input  logic                       chroma_twos,
    input  logic                       in_valid,
    input  logic [NCH-1:0][IN_W-1:0]   in_px,
    output logic                       out_valid,
    output logic [NCH-1:0][CODE_W-1:0] out_px
);

    fmt_t            fmt_q;
    stage_t          s1_q;
    stage_t          s2_q;
    logic            s1_valid;
    code_t [NCH-1:0] lim_c;
    code_t [NCH-1:0] enc_c;

    assign s1_valid = s1_q.valid;

    vcof_cfg_gate u_cfg (
        .clk       (clk),
        .rst       (rst),
        .studio_req(range_studio),
        .twos_req  (chroma_twos),
        .in_valid  (in_valid),
        .s1_valid  (s1_valid),
        .fmt_q     (fmt_q)
    );

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_lim
            vcof_round_sat #(
                .IN_W(IN_W),
                .FRAC(FRAC),
                .KIND(kind_of(g))
            ) u_rs (
                .din (in_px[g]),
                .fmt (fmt_q),
                .code(lim_c[g])
            );
        end
    endgenerate

    // stage 1: rounded and limited codes
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
        end else begin
            s1_q.valid <= in_valid;
            if (in_valid)
                s1_q.code <= lim_c;
        end
    end

    vcof_encode u_enc (
        .code_in (s1_q.code),
        .fmt     (fmt_q),
        .code_out(enc_c)
    );

    // stage 2: final coding
    always_ff @(posedge clk) begin
        if (rst) begin
            s2_q <= '0;
        end else begin
            s2_q.valid <= s1_q.valid;
            if (s1_q.valid)
                s2_q.code <= enc_c;
        end
    end

    assign out_valid = s2_q.valid;
    assign out_px    = s2_q.code;

endmodule

// File: rtl/vcof_checker.sv
module vcof_checker
    import vcof_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic                       in_valid,
    input logic                       s1_valid,
    input fmt_t                       fmt_q,
    input logic                       out_valid,
    input logic [NCH-1:0][CODE_W-1:0] out_px
);

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_chk
            if (kind_of(g) == KIND_LUMA) begin : g_luma
                assert_luma_window_R3: assert property (@(posedge clk) disable iff (rst)
                    (out_valid && fmt_q.studio) |-> (out_px[g] >= 8'd16 && out_px[g] <= 8'd235));
            end else begin : g_chroma
                assert_chroma_window_R4: assert property (@(posedge clk) disable iff (rst)
                    (out_valid && fmt_q.studio && !fmt_q.twos) |-> (out_px[g] >= 8'd16 && out_px[g] <= 8'd240));
                assert_chroma_signed_span_R7: assert property (@(posedge clk) disable iff (rst)
                    (out_valid && fmt_q.studio && fmt_q.twos) |->
                    ($signed(out_px[g]) >= -8'sd112 && $signed(out_px[g]) <= 8'sd112));
            end
        end
    endgenerate

    assert_valid_latency_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid);

    assert_idle_latency_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##2 !out_valid);

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !out_valid |=> (!out_valid |-> $stable(out_px)));

    assert_format_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid || s1_valid) |=> $stable(fmt_q));

    assert_reset_clears_R10: assert property (@(posedge clk)
        rst |=> (!out_valid && out_px == '0));

endmodule

bind vcof_formatter vcof_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .s1_valid (s1_valid),
    .fmt_q    (fmt_q),
    .out_valid(out_valid),
    .out_px   (out_px)
);

// File: tb/vcof_formatter_tb.sv
module vcof_formatter_tb;
    import vcof_pkg::*;

    localparam int IN_W = 16;
    localparam int FRAC = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic range_studio = 1'b0;
    logic chroma_twos = 1'b0;
    logic in_valid = 1'b0;
    logic [NCH-1:0][IN_W-1:0] in_px = '0;
    logic out_valid;
    logic [NCH-1:0][CODE_W-1:0] out_px;

    vcof_formatter #(.IN_W(IN_W), .FRAC(FRAC)) u_dut (
        .clk(clk), .rst(rst), .range_studio(range_studio), .chroma_twos(chroma_twos),
        .in_valid(in_valid), .in_px(in_px), .out_valid(out_valid), .out_px(out_px)
    );

    typedef struct {
        logic [NCH-1:0][7:0] exp;
        int                  cyc;
        string               tag;
    } item_t;

    item_t sb[$];
    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit eff_studio = 1'b0;
    bit eff_twos = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc = cyc + 1;

    function automatic logic [7:0] model(int x, bit studio, bit twos, bit chroma);
        int v, r, lo, hi;
        v = x + 8;
        if (v >= 0) r = v / 16;
        else        r = -((-v + 15) / 16);
        lo = studio ? 16 : 0;
        hi = studio ? (chroma ? 240 : 235) : 255;
        if (r < lo) r = lo;
        if (r > hi) r = hi;
        if (chroma && twos) r = r ^ 128;
        return 8'(r);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drives one pixel in the current cycle and queues its expectation
    task automatic drive(input string tag, input int r, input int g, input int b,
                         input int y, input int cr, input int cb);
        item_t it;
        int v[NCH];
        v[0] = r; v[1] = g; v[2] = b; v[3] = y; v[4] = cr; v[5] = cb;
        in_valid = 1'b1;
        for (int i = 0; i < NCH; i++) begin
            in_px[i] = 16'(v[i]);
            it.exp[i] = model(v[i], eff_studio, eff_twos, kind_of(i) == KIND_CHROMA);
        end
        it.cyc = cyc;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic send(input string tag, input int r, input int g, input int b,
                        input int y, input int cr, input int cb);
        @(negedge clk);
        drive(tag, r, g, b, y, cr, cb);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic set_fmt(input bit s, input bit t);
        @(negedge clk);
        in_valid = 1'b0;
        range_studio = s;
        chroma_twos = t;
        idle(2);
        eff_studio = s;
        eff_twos = t;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R8 unexpected output", 64'(out_px), 64'(0));
            end else begin
                item_t it;
                it = sb.pop_front();
                check(out_px == it.exp, it.tag, 64'(out_px), 64'(it.exp));
                check(cyc == it.cyc + 2, "R8 latency", 64'(cyc - it.cyc), 64'(2));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL R8 watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // request studio + twos while in reset; the active format must stay default
        range_studio = 1'b1;
        chroma_twos = 1'b1;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R10 reset valid", 64'(out_valid), 64'(0));
        check(out_px == '0, "R10 reset data", 64'(out_px), 64'(0));

        // release reset with a pixel already presented: default format applies
        @(negedge clk);
        rst = 1'b0;
        drive("R10 default full/offset", 300*16, -16, 24, 4080, 0, 128*16);
        // burst continues: requested format must not apply yet (R9)
        send("R1 R9 rounding in burst", 23, 40, -8, 24, 2040, 2039);
        send("R2 R9 extremes in burst", 32767, -32768, 4087, 4088, -200, 9000);
        idle(2);
        eff_studio = 1'b1;
        eff_twos = 1'b1;

        // studio + twos
        send("R7 R3 studio twos", 10*16, 240*16, 100*16, 3768, 0, 255*16);
        send("R7 studio twos mid", 0, 0, 0, 0, 128*16, 127*16);
        send("R5 luma unsigned twos", 200*16, 16*16, 235*16, 128*16, 200*16, 50*16);

        // full + offset
        set_fmt(1'b0, 1'b0);
        send("R1 half-up", 24, 23, 40, -8, 2040, 2039);
        send("R2 full clamp", -16, 4800, 32767, -32768, -1, 4096);
        send("R6 offset chroma", 0, 0, 0, 0, 128*16, 127*16);
        idle(1);
        send("R8 after gap", 55*16, 1, 7, 9, 8, 255*16+7);

        // studio + offset
        set_fmt(1'b1, 1'b0);
        send("R3 studio luma", 10*16, 240*16, 100*16, 3768, 128*16, 128*16);
        send("R4 studio chroma", 0, 0, 0, 0, 10*16, 245*16);
        send("R4 studio chroma edge", 16*16, 235*16, 15*16, 236*16, 240*16, 3848);

        // full + twos
        set_fmt(1'b0, 1'b1);
        send("R7 full twos", 200*16, 0, 0, 0, 128*16, 127*16);
        send("R7 full twos ends", 0, 0, 0, 200*16, 255*16, 0);
        // control change mid-burst must be ignored (R9)
        send("R9 burst start", 250*16, 0, 0, 0, 0, 0);
        range_studio = 1'b1;
        chroma_twos = 1'b0;
        send("R9 burst pins changed", 250*16, 5*16, 0, 0, 255*16, 0);
        send("R9 burst end", 250*16, 0, 0, 0, 128*16, 0);
        idle(2);
        eff_studio = 1'b1;
        eff_twos = 1'b0;
        send("R9 new format applied", 250*16, 5*16, 0, 0, 255*16, 0);

        idle(4);
        check(sb.size() == 0, "R8 all outputs seen", 64'(sb.size()), 64'(0));
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule